// File: doc/BRIEF.md
# HD Sample Blanking and Code Protection Stage

This stage sits in a 20-bit HD video datapath, where the upper ten bits carry a luma sample and the lower ten bits carry a chroma sample. On every pixel clock it registers one conditioned word. An active-low blank control, sampled on the same clock, replaces both samples with their blanking levels. Those levels are 0x040 for luma and 0x200 for chroma.

A protect enable makes sure that active video holds only legal code values. With protection on, the stage checks any sample in the active picture area. Values that fall in the reserved low range become the lowest legal code. Values that fall in the reserved high range become the highest legal code. The stage never touches samples in the horizontal or vertical blanking intervals. An upstream timing flag marks the active picture area. The stage delays that flag by one cycle, so it stays aligned with the registered samples.

Top module: `hd_sample_conditioner`

## Requirements
- R1: While reset is asserted, and in the first cycle after release, `dout` holds luma 0x040 in bits [19:10] and chroma 0x200 in bits [9:0], and `active_q` is 0.
- R2: When `blank_n` is 0 at a clock edge, `dout` from that edge shows luma 0x040 and chroma 0x200, whatever the values of `din`, `protect_en` and `active`.
- R3: When `blank_n` is 1 and `protect_en` is 0, `dout` equals the `din` sampled at the same edge. This holds for every code value, including 0x000-0x003 and 0x3FC-0x3FF.
- R4: When `blank_n`, `protect_en` and `active` are all 1, a sample in the range 0x000-0x003 on either channel is output as 0x004.
- R5: When `blank_n`, `protect_en` and `active` are all 1, a sample in the range 0x3FC-0x3FF on either channel is output as 0x3FB.
- R6: When `blank_n`, `protect_en` and `active` are all 1, a sample in the range 0x004-0x3FB passes through unchanged.
- R7: When `active` is 0 and `blank_n` is 1, samples pass unchanged even if `protect_en` is 1.
- R8: The two channels are clamped independently. Each 10-bit field is judged only on its own value.
- R9: `active_q` equals the `active` sampled at the previous clock edge. This gives the flag the same single cycle of latency as `dout`.
- R10: When `blank_n` is 0 and protection would otherwise apply, the blanking levels win.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blank_n | input | 1 | 0 forces blanking levels, 1 lets samples through |
| protect_en | input | 1 | Enables reserved-code remapping in active video |
| active | input | 1 | 1 while the sample lies in the active picture area |
| din | input | 20 | Luma in [19:10], chroma in [9:0] |
| dout | output | 20 | Registered conditioned sample pair |
| active_q | output | 1 | Active flag delayed to line up with `dout` |

## Verification
The hardest case to reach is a pair where each channel needs a different treatment in the same cycle. Examples are luma in the low reserved range while chroma sits in the high reserved range, or one channel reserved while the other is legal. At the same time, protection, active and blank must all be enabled. Uniform random 10-bit values hit the eight reserved codes only rarely. The stimulus therefore draws each channel separately from a mix of the low reserved range, the high reserved range, the exact boundaries 0x004/0x3FB, and fully random values. Directed cycles cover the reserved codes while `active` is low, and with blank forced together with protection.

// File: rtl/hd_sample_conditioner.sv
module hd_sample_conditioner #(
  parameter int SW         = 10,
  parameter int LUMA_BLANK = 'h040,
  parameter int CHRM_BLANK = 'h200,
  parameter int LOW_LEGAL  = 'h004,
  parameter int HIGH_LEGAL = 'h3FB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blank_n,
  input  logic          protect_en,
  input  logic          active,
  input  logic [2*SW-1:0] din,
  output logic [2*SW-1:0] dout,
  output logic          active_q
);

  localparam int DW = 2 * SW;
  localparam logic [SW-1:0] LO = SW'(LOW_LEGAL);
  localparam logic [SW-1:0] HI = SW'(HIGH_LEGAL);
  localparam logic [DW-1:0] BLANK_PAIR = {SW'(LUMA_BLANK), SW'(CHRM_BLANK)};

  logic          clamp_on;
  logic [DW-1:0] cond;

  assign clamp_on = protect_en & active;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [SW-1:0] s;
    assign s = din[c*SW +: SW];
    assign cond[c*SW +: SW] = !clamp_on ? s :
                              (s < LO)  ? LO :
                              (s > HI)  ? HI : s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout     <= BLANK_PAIR;
      active_q <= 1'b0;
    end else begin
      dout     <= blank_n ? cond : BLANK_PAIR;
      active_q <= active;
    end
  end

  a_r2_blank_forces_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> dout == BLANK_PAIR);

  a_r9_active_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> active_q == $past(active));

  a_r4_low_luma_lifted: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && protect_en && active && din[DW-1:SW] < LO) |=> dout[DW-1:SW] == LO);

  a_r5_high_chroma_lowered: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && protect_en && active && din[SW-1:0] > HI) |=> dout[SW-1:0] == HI);

  a_r7_no_clamp_outside_active: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !active) |=> dout == $past(din));

  a_r3_pass_when_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !protect_en) |=> dout == $past(din));

endmodule

// File: tb/hd_sample_conditioner_tb.sv
module hd_sample_conditioner_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blank_n = 1'b1, protect_en = 1'b0, active = 1'b0;
  logic [19:0] din = '0;
  logic [19:0] dout;
  logic active_q;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hd_sample_conditioner dut_i (
    .clk(clk), .rst_n(rst_n), .blank_n(blank_n), .protect_en(protect_en),
    .active(active), .din(din), .dout(dout), .active_q(active_q)
  );

  function automatic logic [9:0] clamp10(input logic [9:0] s, input logic on);
    if (!on) return s;
    if (s <= 10'h003) return 10'h004;
    if (s >= 10'h3FC) return 10'h3FB;
    return s;
  endfunction

  function automatic logic [19:0] model(input logic bn, input logic pe, input logic ac,
                                        input logic [19:0] d);
    if (!bn) return {10'h040, 10'h200};
    return {clamp10(d[19:10], pe & ac), clamp10(d[9:0], pe & ac)};
  endfunction

  task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%05h expected=%05h", tag, got, exp);
    end
  endtask

  task automatic step(input string tag, input logic bn, input logic pe, input logic ac,
                      input logic [19:0] d);
    @(negedge clk);
    blank_n = bn; protect_en = pe; active = ac; din = d;
    @(posedge clk); #5;
    chk(tag, dout, model(bn, pe, ac, d));
    chk("R9 active_q", {19'd0, active_q}, {19'd0, ac});
  endtask

  function automatic logic [9:0] pick();
    case ($urandom % 5)
      0: return 10'($urandom % 4);
      1: return 10'h3FC + 10'($urandom % 4);
      2: return ($urandom % 2) ? 10'h004 : 10'h3FB;
      default: return 10'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5EED));
    din = 20'h00000;
    repeat (3) @(posedge clk);
    #5;
    chk("R1 reset dout", dout, {10'h040, 10'h200});
    chk("R1 reset active_q", {19'd0, active_q}, 20'd0);
    @(negedge clk); rst_n = 1'b1; blank_n = 1'b0;
    @(posedge clk); #5;
    chk("R1 after release", dout, {10'h040, 10'h200});

    step("R2 blank random", 1'b0, 1'b0, 1'b1, 20'h12345);
    step("R3 pass low code", 1'b1, 1'b0, 1'b1, {10'h000, 10'h3FF});
    step("R3 pass mid", 1'b1, 1'b0, 1'b0, {10'h2A5, 10'h15A});
    step("R4 low both", 1'b1, 1'b1, 1'b1, {10'h003, 10'h000});
    step("R5 high both", 1'b1, 1'b1, 1'b1, {10'h3FC, 10'h3FF});
    step("R6 boundaries", 1'b1, 1'b1, 1'b1, {10'h004, 10'h3FB});
    step("R7 inactive reserved", 1'b1, 1'b1, 1'b0, {10'h001, 10'h3FE});
    step("R8 mixed low/high", 1'b1, 1'b1, 1'b1, {10'h002, 10'h3FD});
    step("R8 reserved vs legal", 1'b1, 1'b1, 1'b1, {10'h1F0, 10'h3FF});
    step("R10 blank over protect", 1'b0, 1'b1, 1'b1, {10'h000, 10'h3FF});

    for (int i = 0; i < 2000; i++) begin
      logic bn, pe, ac;
      bn = ($urandom % 8) != 0;
      pe = $urandom % 2;
      ac = ($urandom % 4) != 0;
      step(!bn ? "R2/R10 random" : (pe && ac) ? "R4/R5/R6/R8 random" :
           (pe ? "R7 random" : "R3 random"), bn, pe, ac, {pick(), pick()});
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule